// File: doc/BRIEF.md
# Spread-Spectrum Differential PWM Modulator

This block turns a signed audio sample into two pulse-width-modulated drive signals for a bridge-tied speaker that is driven without an output filter. Both drives start every switching period high together, so with a zero sample they are identical square waves and no net voltage appears across the load. A non-zero sample lengthens the high time of one drive and shortens the other by the same number of clocks. The difference between the two pulse widths forms the output voltage.

The nominal switching rate is 300 kHz, derived from the system clock frequency. When spreading is switched on, a 16-bit pseudo-random sequence picks a fresh period length at every period boundary, anywhere within ±30 % of nominal. The duty thresholds are recomputed from that period, so the high times scale with the period and the average output voltage does not change. A sample offered with its valid strobe is held and takes effect at the next period boundary. Dropping the channel enable forces both drives low, and raising it again starts a new period at once.

Top module: `sspwm_mod`

## Requirements
- R1: With a held sample of 0, both drives are high for exactly floor(P/2) clocks from the start of every period of P clocks and low for the rest, rising on the same clock.
- R2: With held sample s (16-bit two's complement), let d = floor(s·P/65536) and h = floor(P/2). In a period of P clocks the positive drive is high for h+d clocks and the negative drive for h−d clocks, each limited as in R7. This scaling applies whatever period was picked.
- R3: A negative sample gives the positive drive the shorter high time and the negative drive the longer one, by the same formula as R2.
- R4: With spreading on, every period lies in [N−floor(0.3·N), N+floor(0.3·N)], where N = floor(f_clk/300 kHz) (466..866 exclusive bounds give 467..865 clocks at 200 MHz). Period lengths vary from one period to the next.
- R5: With spreading off, every period that starts while it is off lasts exactly N clocks (666 at 200 MHz).
- R6: One clock after the enable is seen low, both drives are low and stay low. One clock after it is seen high again, both drives are high and a fresh period begins, N clocks long when spreading is off.
- R7: Each drive's high time is kept within [1, P−1] clocks, so every period holds at least one high clock and one low clock on both drives, even at full-scale samples.
- R8: The period length and duty thresholds change only at period boundaries. A sample accepted in the middle of a period does not alter that period and governs the next one.
- R9: The sample input is taken only in a clock where the valid strobe is high; changes without the strobe have no effect on the drives.
- R10: While reset is asserted both drives are low; after release with the enable high, both drives rise on the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 16 | Signed audio sample, two's complement |
| sample_vld | input | 1 | Strobe that captures sample_in |
| ss_en | input | 1 | 1 = spread period, 0 = fixed nominal period |
| chan_en | input | 1 | Channel enable; 0 forces both drives low |
| pwm_p | output | 1 | Positive-side bridge drive |
| pwm_n | output | 1 | Negative-side bridge drive |

## Verification
The hardest case to reach from the ports is a sample that changes part-way through a period. The drives must keep the old duty until the boundary, and that boundary falls on a pseudo-random clock when spreading is on. The stimulus locks onto the rising edge of the positive drive and then strobes a new sample a fixed number of clocks into that period. It measures the current period and the one after it, and checks each against the duty formula using the period length it observed. Full-scale samples of both signs are driven to reach the one-clock pulse limits.

// File: rtl/sspwm_pkg.sv
package sspwm_pkg;

  // Map a pseudo-random word onto [lo, lo+span-1] by scaling, not modulo.
  function automatic int pick_span(input longint r, input int lw, input int lo, input int span);
    longint v;
    v = (r * longint'(span)) >>> lw;
    return lo + int'(v);
  endfunction

  // High-time of one drive for period p and signed sample s of width sw.
  function automatic int duty_edge(input int s, input int p, input int sw, input bit pos);
    longint d;
    longint t;
    d = (longint'(s) * longint'(p)) >>> sw;
    t = longint'(p / 2) + (pos ? d : -d);
    if (t < 1) t = 1;
    if (t > longint'(p - 1)) t = longint'(p - 1);
    return int'(t);
  endfunction

endpackage

// File: rtl/sspwm_lfsr.sv
module sspwm_lfsr #(
  parameter int          LW   = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [LW-1:0] state
);
  logic [LW-1:0] nxt;

  always_comb begin
    nxt = {1'b0, state[LW-1:1]};
    if (state[0]) nxt = nxt ^ TAPS[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED[LW-1:0];
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/sspwm_period_sel.sv
module sspwm_period_sel
  import sspwm_pkg::*;
#(
  parameter int LW    = 16,
  parameter int PW    = 10,
  parameter int NOM_P = 666,
  parameter int MIN_P = 467,
  parameter int SPAN  = 399
) (
  input  logic [LW-1:0] rnd,
  input  logic          ss_en,
  output logic [PW-1:0] nxt_per
);
  logic [PW-1:0] spread_per;

  always_comb begin
    spread_per = PW'(pick_span(longint'(rnd), LW, MIN_P, SPAN));
    nxt_per    = ss_en ? spread_per : PW'(NOM_P);
  end
endmodule

// File: rtl/sspwm_duty.sv
module sspwm_duty
  import sspwm_pkg::*;
#(
  parameter int SW = 16,
  parameter int PW = 10
) (
  input  logic [PW-1:0]        per,
  input  logic signed [SW-1:0] samp,
  output logic [PW-1:0]        thr_p,
  output logic [PW-1:0]        thr_n
);
  always_comb begin
    thr_p = PW'(duty_edge(int'(samp), int'(per), SW, 1'b1));
    thr_n = PW'(duty_edge(int'(samp), int'(per), SW, 1'b0));
  end
endmodule

// File: rtl/sspwm_mod.sv
module sspwm_mod #(
  parameter int          CLK_HZ     = 200_000_000,
  parameter int          SWITCH_HZ  = 300_000,
  parameter int          SPREAD_PCT = 30,
  parameter int          SW         = 16,
  parameter int          LW         = 16,
  parameter logic [15:0] LFSR_TAPS  = 16'hB400,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] sample_in,
  input  logic                 sample_vld,
  input  logic                 ss_en,
  input  logic                 chan_en,
  output logic                 pwm_p,
  output logic                 pwm_n
);
  localparam int NOM_P = CLK_HZ / SWITCH_HZ;
  localparam int DEV_P = (NOM_P * SPREAD_PCT) / 100;
  localparam int MIN_P = NOM_P - DEV_P;
  localparam int MAX_P = NOM_P + DEV_P;
  localparam int SPAN  = MAX_P - MIN_P + 1;
  localparam int PW    = $clog2(MAX_P + 1);

  logic signed [SW-1:0] samp_q;
  logic [PW-1:0]        cnt_q, per_q, thr_p_q, thr_n_q;
  logic                 run_q;
  logic [LW-1:0]        rnd;
  logic [PW-1:0]        nxt_per, nxt_thr_p, nxt_thr_n;
  logic                 last_cyc, load_ev;

  // Named events for the assertions.
  assign last_cyc = (cnt_q == per_q - PW'(1));
  assign load_ev  = chan_en && (!run_q || last_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          samp_q <= '0;
    else if (sample_vld) samp_q <= sample_in;
  end

  sspwm_lfsr #(.LW(LW), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (load_ev && ss_en),
    .state (rnd)
  );

  sspwm_period_sel #(.LW(LW), .PW(PW), .NOM_P(NOM_P), .MIN_P(MIN_P), .SPAN(SPAN)) u_psel (
    .rnd     (rnd),
    .ss_en   (ss_en),
    .nxt_per (nxt_per)
  );

  sspwm_duty #(.SW(SW), .PW(PW)) u_duty (
    .per   (nxt_per),
    .samp  (samp_q),
    .thr_p (nxt_thr_p),
    .thr_n (nxt_thr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      per_q   <= PW'(NOM_P);
      thr_p_q <= PW'(NOM_P / 2);
      thr_n_q <= PW'(NOM_P / 2);
    end else if (!chan_en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_ev) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      per_q   <= nxt_per;
      thr_p_q <= nxt_thr_p;
      thr_n_q <= nxt_thr_n;
    end else begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

  assign pwm_p = run_q && (cnt_q < thr_p_q);
  assign pwm_n = run_q && (cnt_q < thr_n_q);

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!pwm_p && !pwm_n)); // R6
  AST_WAKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !run_q) |=> (pwm_p && pwm_n)); // R6
  AST_PERIOD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q >= PW'(MIN_P) && per_q <= PW'(MAX_P))); // R4
  AST_FIXED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !ss_en) |=> (per_q == PW'(NOM_P))); // R5
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && chan_en && !load_ev) |=> ($stable(per_q) && $stable(thr_p_q) && $stable(thr_n_q))); // R8
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (thr_p_q >= PW'(1) && thr_p_q < per_q && thr_n_q >= PW'(1) && thr_n_q < per_q)); // R7
  AST_ZERO_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && samp_q == '0) |=> (thr_p_q == thr_n_q)); // R1
endmodule

// File: tb/sspwm_mod_bench.sv
`timescale 1ns/1ps
module sspwm_mod_bench;
  localparam int NOM = 666;
  localparam int LO  = 467;
  localparam int HI  = 865;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic sample_vld = 1'b0;
  logic ss_en = 1'b0;
  logic chan_en = 1'b1;
  logic pwm_p, pwm_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sspwm_mod u_sspwm_mod (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sample_vld(sample_vld),
    .ss_en(ss_en), .chan_en(chan_en), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected high time, from the requirement formula.
  function automatic int exp_hi(input int s, input int p, input bit pos);
    longint prod, d, t;
    prod = longint'(s) * longint'(p);
    d = prod / 65536;
    if (prod < 0 && (prod % 65536) != 0) d = d - 1;
    t = (p / 2) + (pos ? d : -d);
    if (t < 1) t = 1;
    if (t > p - 1) t = p - 1;
    return int'(t);
  endfunction

  task automatic load_sample(input logic signed [15:0] v);
    @(negedge clk);
    sample_in = v; sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  // Lock onto a rising edge of pwm_p, then measure one full period.
  task automatic measure(output int p, output int hp, output int hn,
                         input int inj_at, input logic signed [15:0] inj_val);
    bit pv;
    pv = 1'b1;
    forever begin
      @(negedge clk);
      if (pwm_p && !pv) break;
      pv = pwm_p;
    end
    p = 0; hp = 0; hn = 0;
    forever begin
      hp += int'(pwm_p); hn += int'(pwm_n); p++;
      pv = pwm_p;
      if (p == inj_at) begin sample_in = inj_val; sample_vld = 1'b1; end
      @(negedge clk);
      sample_vld = 1'b0;
      if (pwm_p && !pv) break;
    end
  endtask

  task automatic duty_case(input string req, input int s);
    int p, hp, hn;
    load_sample(16'(s));
    measure(p, hp, hn, -1, '0);
    check(p == NOM, {req, " period"}, p, NOM);
    check(hp == exp_hi(s, p, 1'b1), {req, " pos high"}, hp, exp_hi(s, p, 1'b1));
    check(hn == exp_hi(s, p, 1'b0), {req, " neg high"}, hn, exp_hi(s, p, 1'b0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!pwm_p && !pwm_n, "R10 low in reset", int'(pwm_p | pwm_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_p && pwm_n, "R10 rise after reset", int'(pwm_p & pwm_n), 1);
  endtask

  task automatic t_zero;
    int p, hp, hn;
    load_sample(16'sd0);
    measure(p, hp, hn, -1, '0);
    check(hp == p / 2, "R1 zero pos high", hp, p / 2);
    check(hn == hp, "R1 zero twin", hn, hp);
  endtask

  task automatic t_clamp;
    int p, hp, hn;
    load_sample(16'sh7FFF);
    measure(p, hp, hn, -1, '0);
    check(hp >= 1 && p - hp >= 1 && hn >= 1, "R7 full positive", hp, p - 1);
    check(hn == 1, "R7 full positive neg high", hn, 1);
    load_sample(16'sh8000);
    measure(p, hp, hn, -1, '0);
    check(hp == 1, "R7 full negative pos high", hp, 1);
    check(hn == p - 1, "R7 full negative neg high", hn, p - 1);
  endtask

  task automatic t_spread;
    int p, hp, hn, pmin, pmax;
    pmin = 100000; pmax = 0;
    ss_en = 1'b1;
    load_sample(16'sd5000);
    measure(p, hp, hn, -1, '0);
    for (int i = 0; i < 16; i++) begin
      measure(p, hp, hn, -1, '0);
      check(p >= LO && p <= HI, "R4 period span", p, NOM);
      check(hp == exp_hi(5000, p, 1'b1), "R2 scaled pos high", hp, exp_hi(5000, p, 1'b1));
      check(hn == exp_hi(5000, p, 1'b0), "R2 scaled neg high", hn, exp_hi(5000, p, 1'b0));
      if (p < pmin) pmin = p;
      if (p > pmax) pmax = p;
    end
    check(pmax > pmin, "R4 period varies", pmax - pmin, 1);
  endtask

  task automatic t_fixed;
    int p, hp, hn;
    ss_en = 1'b0;
    measure(p, hp, hn, -1, '0);
    for (int i = 0; i < 3; i++) begin
      measure(p, hp, hn, -1, '0);
      check(p == NOM, "R5 fixed period", p, NOM);
    end
  endtask

  task automatic t_gate;
    int p;
    bit pv;
    @(negedge clk);
    chan_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!pwm_p && !pwm_n, "R6 disabled low", int'(pwm_p | pwm_n), 0);
    end
    chan_en = 1'b1;
    @(negedge clk);
    check(pwm_p && pwm_n, "R6 restart high", int'(pwm_p & pwm_n), 1);
    p = 1; pv = pwm_p;
    forever begin
      @(negedge clk);
      if (pwm_p && !pv) break;
      pv = pwm_p; p++;
    end
    check(p == NOM, "R6 fresh period", p, NOM);
  endtask

  task automatic t_midchange;
    int p, hp, hn;
    load_sample(-16'sd8000);
    measure(p, hp, hn, 100, 16'sd9000);
    check(hp == exp_hi(-8000, p, 1'b1), "R8 old duty kept", hp, exp_hi(-8000, p, 1'b1));
    measure(p, hp, hn, -1, '0);
    check(hp == exp_hi(9000, p, 1'b1), "R8 new duty next period", hp, exp_hi(9000, p, 1'b1));
  endtask

  task automatic t_novalid;
    int p, hp, hn;
    load_sample(16'sd3000);
    @(negedge clk);
    sample_in = 16'sd20000;
    measure(p, hp, hn, -1, '0);
    check(hp == exp_hi(3000, p, 1'b1), "R9 strobe-less ignored", hp, exp_hi(3000, p, 1'b1));
    check(hn == exp_hi(3000, p, 1'b0), "R9 strobe-less ignored neg", hn, exp_hi(3000, p, 1'b0));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    duty_case("R2 positive", 10000);
    duty_case("R3 negative", -12345);
    t_clamp();
    t_spread();
    t_fixed();
    t_gate();
    t_midchange();
    t_novalid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule